// File: doc/BRIEF.md
# I2C Slave Byte Engine with Event Status Codes

This block is the target side of a two-wire serial bus. It samples the open-drain SCL and SDA lines with the system clock and decodes START and STOP conditions. It shifts in the address byte and answers when the byte matches its configured 7-bit address or the all-zero broadcast address. It then receives or transmits data bytes. After each bus event it latches an 8-bit status code and raises an interrupt flag toward a host.

While the flag is up, the engine pulls SCL low so that the bus controller waits. The host services the event by reading the received byte or loading the byte to send, and then pulses the flag-clear input. A level input controls whether the engine acknowledges, and a reset pulse returns the engine to idle. The engine also watches for SCL staying high too long while a transfer is open, and for START or STOP conditions that land inside a byte or an acknowledge slot. Each of these faults ends in a sticky error state that only the reset pulse leaves.

Top module: `i2cs_engine`

## Requirements
- R1: After reset, statusCode is 0xF8, irqFlag is 0, and both sclOe and sdaOe are 0 (both lines released).
- R2: When the engine acknowledges its own address with the direction bit 0 (write), it drives SDA low in the ninth clock, sets irqFlag and reports 0x60. While irqFlag is 1, sclOe is 1 and statusCode does not change. The flag stays set until flagClr or stopRst is pulsed.
- R3: When the engine acknowledges address byte 0x00 (broadcast), it reports 0x70.
- R4: A data byte is received MSB first and is then readable on rxData. When the engine acknowledges it (ackEnable=1 at the eighth falling SCL edge), the code is 0x80 after an own-address write and 0x90 after a broadcast. When it answers NACK, the code is 0x88 or 0x98.
- R5: A STOP or repeated START that arrives at a byte boundary (no more than one SCL rise into the next byte) while the engine is receiving or transmitting sets irqFlag with code 0xA0.
- R6: When the engine acknowledges its own address with the direction bit 1 (read), it reports 0xA8. It then shifts out the byte loaded through txLoad/txData, MSB first, on SDA.
- R7: After a transmitted byte, the code is 0xB8 if the bus controller returns ACK and 0xC0 if it returns NACK. The code is 0xC8 if the controller returns ACK and ackEnable was 0 when the byte finished.
- R8: If SCL stays high for toLimit cycles while a transfer is open, the engine sets irqFlag with code 0xD0. flagClr cannot clear this state.
- R9: A START or STOP that arrives mid-byte or in an acknowledge slot while the engine is addressed sets irqFlag with code 0x00. flagClr cannot clear this state.
- R10: A stopRst pulse clears irqFlag and returns the engine to idle, where statusCode reads 0xF8. A STOP that returns an unaddressed engine to idle never sets irqFlag.
- R11: With ackEnable=0, the engine does not acknowledge its own address or the broadcast address and does not set irqFlag.
- R12: An address byte matching neither the own address nor 0x00 gets no acknowledge. The data bytes that follow get none either (even a 0x00 byte) and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclOe | output | 1 | 1 pulls SCL low (clock held) |
| sdaOe | output | 1 | 1 pulls SDA low |
| ownAddr | input | 7 | Own 7-bit address |
| ackEnable | input | 1 | Acknowledge enable |
| toLimit | input | TO_W | SCL-high timeout limit in clock cycles |
| flagClr | input | 1 | Pulse: host clears irqFlag |
| stopRst | input | 1 | Pulse: return to idle, clear errors |
| txLoad | input | 1 | Pulse: load txData into the data register |
| txData | input | 8 | Byte to transmit |
| rxData | output | 8 | Data register contents (received byte) |
| statusCode | output | 8 | Current event status code |
| irqFlag | output | 1 | Event pending for the host |

## Verification
The checker watches several rules on every cycle. The flag stays set until the host clears it, and the status code stays frozen while the flag is pending. The bus-error and timeout codes survive flag-clear pulses, and a reset pulse always leads to the idle code with the flag low. The bench also confirms on every clock that SCL is pulled low while the flag is up. Only the bench's bus scenarios can show the code sequences, the acknowledge values seen on the wire, the received and transmitted byte values, the byte-boundary rule for STOP and repeated START, and the silence toward foreign addresses.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BIT_W = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK, S_WAIT, S_ERR
  } stateT;

  localparam logic [7:0] ST_OWN_W   = 8'h60;
  localparam logic [7:0] ST_GC      = 8'h70;
  localparam logic [7:0] ST_RX_ACK  = 8'h80;
  localparam logic [7:0] ST_RX_NACK = 8'h88;
  localparam logic [7:0] ST_GC_ACK  = 8'h90;
  localparam logic [7:0] ST_GC_NACK = 8'h98;
  localparam logic [7:0] ST_STOP    = 8'hA0;
  localparam logic [7:0] ST_OWN_R   = 8'hA8;
  localparam logic [7:0] ST_TX_ACK  = 8'hB8;
  localparam logic [7:0] ST_TX_NACK = 8'hC0;
  localparam logic [7:0] ST_TX_LAST = 8'hC8;
  localparam logic [7:0] ST_TMO     = 8'hD0;
  localparam logic [7:0] ST_BERR    = 8'h00;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  // strobes from control to datapath
  typedef struct packed {
    logic       cntClr;
    logic       shiftIn;
    logic       shiftOut;
    logic       setFlag;
    logic [7:0] code;
    logic       ackDrive;
    logic       txDrive;
    logic       busy;
    logic       idle;
    logic       errHold;
  } ctlT;

  // observations from datapath to control
  typedef struct packed {
    logic             sclRise;
    logic             sclFall;
    logic             startDet;
    logic             stopDet;
    logic             sdaBit;
    logic             timeout;
    logic [BIT_W-1:0] bitCnt;
    logic [7:0]       shiftByte;
  } obsT;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  input  ctlT             ctl,
  input  logic            stopRst,
  input  logic            flagClr,
  input  logic            txLoad,
  input  logic [7:0]      txData,
  input  logic [TO_W-1:0] toLimit,
  output obsT             obs,
  output logic [7:0]      dataReg,
  output logic            flag,
  output logic [7:0]      statusCode,
  output logic            sdaOe,
  output logic            sclOe
);
  logic sclS, sdaS, sclD, sdaD;
  logic [BIT_W-1:0] bitCnt;
  logic [TO_W-1:0]  hiCnt;
  logic [7:0]       codeReg;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sclSync (.clk(clk), .rstN(rstN), .d(sclIn), .q(sclS));
  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (.clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_comb begin
    obs.sclRise   = sclS & ~sclD;
    obs.sclFall   = ~sclS & sclD;
    obs.startDet  = sclS & sclD & sdaD & ~sdaS;
    obs.stopDet   = sclS & sclD & ~sdaD & sdaS;
    obs.sdaBit    = sdaS;
    obs.timeout   = ctl.busy & sclS & (hiCnt == toLimit) & (toLimit != '0);
    obs.bitCnt    = bitCnt;
    obs.shiftByte = dataReg;
  end

  // bit counter: SCL rises inside the current byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             bitCnt <= '0;
    else if (stopRst || ctl.cntClr)        bitCnt <= '0;
    else if (obs.sclRise && ctl.busy && bitCnt != '1) bitCnt <= bitCnt + 1'b1;
  end

  // shared receive/transmit byte register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataReg <= '0;
    else if (ctl.shiftIn)  dataReg <= {dataReg[6:0], sdaS};
    else if (ctl.shiftOut) dataReg <= {dataReg[6:0], 1'b1};
    else if (txLoad)       dataReg <= txData;
  end

  // SCL-high duration counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           hiCnt <= '0;
    else if (stopRst || !ctl.busy || !sclS) hiCnt <= '0;
    else if (hiCnt != toLimit)           hiCnt <= hiCnt + 1'b1;
  end

  // event flag and latched code
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag    <= 1'b0;
      codeReg <= ST_IDLE;
    end else if (stopRst) begin
      flag    <= 1'b0;
      codeReg <= ST_IDLE;
    end else if (ctl.setFlag) begin
      flag    <= 1'b1;
      codeReg <= ctl.code;
    end else if (flagClr && !ctl.errHold) begin
      flag    <= 1'b0;
    end
  end

  assign statusCode = (ctl.idle && !flag) ? ST_IDLE : codeReg;
  assign sdaOe      = ctl.ackDrive | (ctl.txDrive & ~dataReg[7]);
  assign sclOe      = flag;
endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  obsT        obs,
  input  logic [6:0] ownAddr,
  input  logic       ackEnable,
  input  logic       stopRst,
  output ctlT        ctl
);
  stateT state, nxt;
  logic  isGc, rwBit, rxAck, lastByte, mAck;
  logic  capAddr, capRx, capLast, capAck;
  logic  busEvt, atBoundary, ownHit, gcHit, accept;

  assign busEvt     = obs.startDet | obs.stopDet;
  assign atBoundary = obs.bitCnt <= BIT_W'(1);
  assign ownHit     = obs.shiftByte[7:1] == ownAddr;
  assign gcHit      = obs.shiftByte == 8'h00;
  assign accept     = ackEnable & (ownHit | gcHit);

  always_comb begin
    ctl          = '0;
    nxt          = state;
    capAddr      = 1'b0;
    capRx        = 1'b0;
    capLast      = 1'b0;
    capAck       = 1'b0;
    ctl.busy     = (state != S_IDLE) && (state != S_ERR);
    ctl.idle     = state == S_IDLE;
    ctl.errHold  = state == S_ERR;
    ctl.ackDrive = (state == S_AACK) || (state == S_RACK && rxAck);
    ctl.txDrive  = state == S_TX;

    if (obs.timeout && ctl.busy) begin
      nxt = S_ERR;
      ctl.setFlag = 1'b1;
      ctl.code = ST_TMO;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (obs.startDet) begin
            nxt = S_ADDR;
            ctl.cntClr = 1'b1;
          end
        end
        S_ADDR, S_WAIT: begin
          if (obs.startDet) begin
            nxt = S_ADDR;
            ctl.cntClr = 1'b1;
          end else if (obs.stopDet) begin
            nxt = S_IDLE;
          end else if (state == S_ADDR && obs.sclRise) begin
            ctl.shiftIn = 1'b1;
          end else if (state == S_ADDR && obs.sclFall && obs.bitCnt == BIT_W'(8)) begin
            capAddr = 1'b1;
            nxt = accept ? S_AACK : S_WAIT;
          end
        end
        S_AACK, S_RACK, S_TACK: begin
          if (busEvt) begin
            nxt = S_ERR;
            ctl.setFlag = 1'b1;
            ctl.code = ST_BERR;
          end else if (state == S_TACK && obs.sclRise) begin
            capAck = 1'b1;
          end else if (obs.sclFall) begin
            ctl.setFlag = 1'b1;
            ctl.cntClr  = 1'b1;
            if (state == S_AACK) begin
              nxt = rwBit ? S_TX : S_RX;
              ctl.code = rwBit ? ST_OWN_R : (isGc ? ST_GC : ST_OWN_W);
            end else if (state == S_RACK) begin
              nxt = rxAck ? S_RX : S_WAIT;
              ctl.code = isGc ? (rxAck ? ST_GC_ACK : ST_GC_NACK)
                              : (rxAck ? ST_RX_ACK : ST_RX_NACK);
            end else begin
              nxt = (mAck && !lastByte) ? S_TX : S_WAIT;
              ctl.code = !mAck ? ST_TX_NACK : (lastByte ? ST_TX_LAST : ST_TX_ACK);
            end
          end
        end
        S_RX, S_TX: begin
          if (busEvt) begin
            ctl.setFlag = 1'b1;
            ctl.cntClr  = 1'b1;
            if (atBoundary) begin
              ctl.code = ST_STOP;
              nxt = obs.startDet ? S_ADDR : S_IDLE;
            end else begin
              ctl.code = ST_BERR;
              nxt = S_ERR;
            end
          end else if (state == S_RX && obs.sclRise) begin
            ctl.shiftIn = 1'b1;
          end else if (state == S_RX && obs.sclFall && obs.bitCnt == BIT_W'(8)) begin
            capRx = 1'b1;
            nxt = S_RACK;
          end else if (state == S_TX && obs.sclFall && obs.bitCnt != '0) begin
            ctl.shiftOut = 1'b1;
            if (obs.bitCnt == BIT_W'(8)) begin
              capLast = 1'b1;
              nxt = S_TACK;
            end
          end
        end
        S_ERR: ;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      isGc     <= 1'b0;
      rwBit    <= 1'b0;
      rxAck    <= 1'b0;
      lastByte <= 1'b0;
      mAck     <= 1'b0;
    end else begin
      state <= stopRst ? S_IDLE : nxt;
      if (capAddr) begin
        isGc  <= gcHit;
        rwBit <= obs.shiftByte[0];
      end
      if (capRx)   rxAck    <= ackEnable;
      if (capLast) lastByte <= ~ackEnable;
      if (capAck)  mAck     <= ~obs.sdaBit;
    end
  end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  output logic            sclOe,
  output logic            sdaOe,
  input  logic [6:0]      ownAddr,
  input  logic            ackEnable,
  input  logic [TO_W-1:0] toLimit,
  input  logic            flagClr,
  input  logic            stopRst,
  input  logic            txLoad,
  input  logic [7:0]      txData,
  output logic [7:0]      rxData,
  output logic [7:0]      statusCode,
  output logic            irqFlag
);
  ctlT ctl;
  obsT obs;

  i2cs_control u_ctrl (
    .clk(clk), .rstN(rstN), .obs(obs), .ownAddr(ownAddr),
    .ackEnable(ackEnable), .stopRst(stopRst), .ctl(ctl)
  );

  i2cs_datapath #(.TO_W(TO_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .stopRst(stopRst), .flagClr(flagClr), .txLoad(txLoad), .txData(txData),
    .toLimit(toLimit), .obs(obs), .dataReg(rxData), .flag(irqFlag),
    .statusCode(statusCode), .sdaOe(sdaOe), .sclOe(sclOe)
  );
endmodule

// File: rtl/i2cs_engine_chk.sv
module i2cs_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       irqFlag,
  input logic       flagClr,
  input logic       stopRst,
  input logic [7:0] statusCode
);
  p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !flagClr && !stopRst |=> irqFlag);

  p_code_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && $past(irqFlag) |-> $stable(statusCode));

  p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    stopRst |=> !irqFlag && statusCode == 8'hF8);

  p_berr_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && statusCode == 8'h00 && !stopRst |=> irqFlag && statusCode == 8'h00);

  p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && statusCode == 8'hD0 && !stopRst |=> irqFlag && statusCode == 8'hD0);
endmodule

bind i2cs_engine i2cs_engine_chk u_chk (
  .clk(clk), .rstN(rstN), .irqFlag(irqFlag), .flagClr(flagClr),
  .stopRst(stopRst), .statusCode(statusCode)
);

// File: tb/i2cs_engine_bench.sv
module i2cs_engine_bench;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic mScl = 1'b1, mSda = 1'b1;
  logic sclOe, sdaOe, irqFlag;
  logic [6:0]  ownAddr = 7'h42;
  logic        ackEnable = 1'b1;
  logic [15:0] toLimit = 16'd100;
  logic flagClr = 1'b0, stopRst = 1'b0, txLoad = 1'b0;
  logic [7:0] txData = 8'h00;
  logic [7:0] rxData, statusCode;
  wire sclLine = mScl & ~sclOe;
  wire sdaLine = mSda & ~sdaOe;

  int checks = 0;
  int fails  = 0;
  logic monOn = 1'b0;

  i2cs_engine u_i2cs_engine (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .ownAddr(ownAddr), .ackEnable(ackEnable),
    .toLimit(toLimit), .flagClr(flagClr), .stopRst(stopRst), .txLoad(txLoad),
    .txData(txData), .rxData(rxData), .statusCode(statusCode), .irqFlag(irqFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every clock: a pending event must hold SCL low on the wire (R2)
  always @(negedge clk) begin
    if (monOn && irqFlag) begin
      checks++;
      if (sclLine !== 1'b0) begin
        fails++;
        $display("FAIL R2 scl hold actual=%0b expected=0", sclLine);
      end
    end
  end

  task automatic waitH();
    repeat (H) @(negedge clk);
  endtask

  task automatic waitSclHigh();
    while (sclLine !== 1'b1) @(negedge clk);
  endtask

  task automatic mStart();
    mSda = 1'b1; waitH();
    mScl = 1'b1; waitSclHigh(); waitH();
    mSda = 1'b0; waitH();
    mScl = 1'b0; waitH();
  endtask

  task automatic mStop();
    mSda = 1'b0; waitH();
    mScl = 1'b1; waitSclHigh(); waitH();
    mSda = 1'b1; waitH();
  endtask

  task automatic mBit(input logic b, output logic s);
    mSda = b; waitH();
    mScl = 1'b1; waitSclHigh(); waitH();
    s = sdaLine;
    mScl = 1'b0; waitH();
  endtask

  task automatic mWrite(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) mBit(b[i], s);
    mBit(1'b1, s);
    acked = ~s;
  endtask

  task automatic mRead(input logic giveAck, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      mBit(1'b1, s);
      b[i] = s;
    end
    mBit(~giveAck, s);
  endtask

  task automatic hostClear();
    @(negedge clk) flagClr = 1'b1;
    @(negedge clk) flagClr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hostReset();
    @(negedge clk) stopRst = 1'b1;
    @(negedge clk) stopRst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic hostLoad(input logic [7:0] d);
    @(negedge clk) begin txLoad = 1'b1; txData = d; end
    @(negedge clk) txLoad = 1'b0;
  endtask

  // reference: expected flag and code, compared over several clocks
  task automatic expectHost(input string req, input logic f, input logic [7:0] code);
    repeat (3) begin
      @(negedge clk);
      chk({req, " flag"}, {31'd0, irqFlag}, {31'd0, f});
      chk({req, " code"}, {24'd0, statusCode}, {24'd0, code});
    end
  endtask

  initial begin
    repeat (25000) @(negedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    monOn = 1'b1;

    // R1 reset state
    expectHost("R1", 1'b0, 8'hF8);
    chk("R1 sclOe", {31'd0, sclOe}, 32'd0);
    chk("R1 sdaOe", {31'd0, sdaOe}, 32'd0);

    // R2 / R4 own-address write, ACK then NACK data
    mStart();
    mWrite(8'h84, ack);
    chk("R2 addr ack", {31'd0, ack}, 32'd1);
    expectHost("R2", 1'b1, 8'h60);
    hostClear();
    expectHost("R2 cleared", 1'b0, 8'h60);
    mWrite(8'hA5, ack);
    chk("R4 data ack", {31'd0, ack}, 32'd1);
    expectHost("R4", 1'b1, 8'h80);
    chk("R4 rxData", {24'd0, rxData}, 32'hA5);
    ackEnable = 1'b0;
    hostClear();
    mWrite(8'h3C, ack);
    chk("R4 data nack", {31'd0, ack}, 32'd0);
    expectHost("R4", 1'b1, 8'h88);
    chk("R4 rxData", {24'd0, rxData}, 32'h3C);
    ackEnable = 1'b1;
    hostClear();
    mStop();
    expectHost("R10 idle no flag", 1'b0, 8'hF8);

    // R5 STOP at a byte boundary
    mStart();
    mWrite(8'h84, ack);
    hostClear();
    mWrite(8'h11, ack);
    hostClear();
    mStop();
    expectHost("R5 stop", 1'b1, 8'hA0);
    hostClear();
    expectHost("R10", 1'b0, 8'hF8);

    // R5 repeated START, then R6 / R7 read with ACK and NACK
    mStart();
    mWrite(8'h84, ack);
    hostClear();
    mStart();
    expectHost("R5 rstart", 1'b1, 8'hA0);
    hostClear();
    mWrite(8'h85, ack);
    chk("R6 addr ack", {31'd0, ack}, 32'd1);
    expectHost("R6", 1'b1, 8'hA8);
    hostLoad(8'h5A);
    hostClear();
    mRead(1'b1, b);
    chk("R6 tx byte", {24'd0, b}, 32'h5A);
    expectHost("R7 ack", 1'b1, 8'hB8);
    hostLoad(8'hC3);
    hostClear();
    mRead(1'b0, b);
    chk("R6 tx byte", {24'd0, b}, 32'hC3);
    expectHost("R7 nack", 1'b1, 8'hC0);
    hostClear();
    mStop();
    expectHost("R10", 1'b0, 8'hF8);

    // R7 last byte with acknowledge disabled
    mStart();
    mWrite(8'h85, ack);
    hostLoad(8'h96);
    hostClear();
    mRead(1'b1, b);
    chk("R6 tx byte", {24'd0, b}, 32'h96);
    expectHost("R7 ack", 1'b1, 8'hB8);
    ackEnable = 1'b0;
    hostLoad(8'h0F);
    hostClear();
    mRead(1'b1, b);
    chk("R6 tx byte", {24'd0, b}, 32'h0F);
    expectHost("R7 last", 1'b1, 8'hC8);
    ackEnable = 1'b1;
    hostClear();
    mStop();
    expectHost("R10", 1'b0, 8'hF8);

    // R3 broadcast address, R4 broadcast data codes
    mStart();
    mWrite(8'h00, ack);
    chk("R3 gc ack", {31'd0, ack}, 32'd1);
    expectHost("R3", 1'b1, 8'h70);
    hostClear();
    mWrite(8'h77, ack);
    expectHost("R4 gc ack", 1'b1, 8'h90);
    chk("R4 gc rxData", {24'd0, rxData}, 32'h77);
    ackEnable = 1'b0;
    hostClear();
    mWrite(8'h12, ack);
    chk("R4 gc nack", {31'd0, ack}, 32'd0);
    expectHost("R4 gc nack", 1'b1, 8'h98);
    ackEnable = 1'b1;
    hostClear();
    mStop();
    expectHost("R10", 1'b0, 8'hF8);

    // R11 acknowledge disabled: own and broadcast addresses ignored
    ackEnable = 1'b0;
    mStart();
    mWrite(8'h84, ack);
    chk("R11 own nack", {31'd0, ack}, 32'd0);
    chk("R11 no flag", {31'd0, irqFlag}, 32'd0);
    mStart();
    mWrite(8'h00, ack);
    chk("R11 gc nack", {31'd0, ack}, 32'd0);
    chk("R11 no flag", {31'd0, irqFlag}, 32'd0);
    mStop();
    ackEnable = 1'b1;
    expectHost("R11 idle", 1'b0, 8'hF8);

    // R12 foreign address and following bytes ignored
    mStart();
    mWrite(8'h66, ack);
    chk("R12 addr nack", {31'd0, ack}, 32'd0);
    mWrite(8'h00, ack);
    chk("R12 data nack", {31'd0, ack}, 32'd0);
    chk("R12 no flag", {31'd0, irqFlag}, 32'd0);
    mStop();
    expectHost("R12 idle", 1'b0, 8'hF8);

    // R9 START in the middle of a byte
    mStart();
    mWrite(8'h84, ack);
    hostClear();
    mBit(1'b1, ack);
    mBit(1'b0, ack);
    mBit(1'b1, ack);
    mStart();
    expectHost("R9 berr", 1'b1, 8'h00);
    hostClear();
    expectHost("R9 sticky", 1'b1, 8'h00);
    hostReset();
    expectHost("R10 reset", 1'b0, 8'hF8);
    mStop();
    expectHost("R10", 1'b0, 8'hF8);

    // R8 SCL held high past the limit
    mStart();
    mWrite(8'h84, ack);
    hostClear();
    mSda = 1'b1;
    mScl = 1'b1;
    repeat (160) @(negedge clk);
    expectHost("R8 timeout", 1'b1, 8'hD0);
    hostClear();
    expectHost("R8 sticky", 1'b1, 8'hD0);
    hostReset();
    expectHost("R10 reset", 1'b0, 8'hF8);
    chk("R10 scl free", {31'd0, sclLine}, 32'd1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule